// File: doc/BRIEF.md
# UART Internal Loopback and Modem-Status Mirror

This block sits between a UART's register write port and its receive buffer and provides the internal loopback test mode. A control register holds a loopback-enable bit and four software-driven modem control outputs. While loopback is on, every control write copies those outputs onto the four modem status flags in a crossed pattern and refreshes the modem-status interrupt bits from the new flags. Words written to the data register, and break markers raised by the line register's send-break bit, go straight into the receive stream. Characters arriving on the external receive input are thrown away.

While loopback is off, control writes are still stored but leave the flags alone. External characters flow into the receive stream instead. All words bound for the receive buffer pass through a small holding queue. The receive output is a valid/ready stream: a word stays presented, unchanged, until the consumer takes it. The external receive input is also valid/ready, and it is stalled only when loopback is off and the queue is full. Loopback pushes arrive on register writes, which cannot be stalled, so a push that meets a full queue is lost.

Top module: `uart_loopback_path`

## Requirements
- R1: After reset the stored control word, the modem flags and the modem interrupt bits are all zero, and the receive output is not valid.
- R2: A control write (reg_sel 3) whose bit 7 is 1 sets, one cycle later, modem_flags bit 0 (ring) from written bit 13, bit 1 (clear-to-send) from bit 11, bit 2 (carrier detect) from bit 12 and bit 3 (data-set-ready) from bit 10. This includes the write that first turns loopback on.
- R3: After such a write the four modem interrupt bits, in the same bit order, equal the new flags, so a bit set earlier whose flag is now low reads as 0.
- R4: Every control write stores the full 16-bit word in ctrl_reg. A control write with bit 7 at 0 leaves modem_flags and modem_irq unchanged.
- R5: Writes to the flag register (reg_sel 1), the data register (reg_sel 0) and the line register (reg_sel 2) leave modem_flags and modem_irq unchanged.
- R6: With the stored bit 7 set, a data write (reg_sel 0) pushes the 11-bit word {3'b000, wdata[7:0]} into the receive stream. With it clear, a data write pushes nothing.
- R7: With loopback on, a line write (reg_sel 2) that raises bit 0 from 0 to 1 pushes the break word 11'h400. A line write that leaves bit 0 at 1, or clears it, pushes nothing.
- R8: With loopback on, ext_rx_ready is 1 and every offered external character is discarded.
- R9: With loopback off, an external character is accepted whenever the queue is not full and appears as {3'b000, data}. ext_rx_ready is 0 while the queue holds FIFO_DEPTH words.
- R10: While rxq_valid is 1 and rxq_ready is 0, rxq_valid and rxq_data hold. Words leave in the order they entered.
- R11: A push that finds FIFO_DEPTH (default 4) words already queued is dropped, and the queued words are delivered unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Target: 0 data, 1 flag, 2 line, 3 control |
| reg_wdata | input | 16 | Write data |
| ext_rx_valid | input | 1 | External character offered |
| ext_rx_ready | output | 1 | External character taken or discarded |
| ext_rx_data | input | 8 | External character |
| rxq_valid | output | 1 | Receive word available |
| rxq_ready | input | 1 | Receive buffer accepts the word |
| rxq_data | output | 11 | Receive word, bit 10 marks a break |
| ctrl_reg | output | 16 | Stored control word |
| modem_flags | output | 4 | Modem status flags: 3 DSR, 2 DCD, 1 CTS, 0 RI |
| modem_irq | output | 4 | Modem-status interrupt bits, same order |

## Verification
A wrong bit in the crossed mapping shows up on modem_flags in the cycle after the control write that enables loopback. A stale interrupt bit that is not cleared shows on modem_irq in that same cycle. A break-edge detector that keeps the wrong previous state either loses a 0x400 word or adds an extra one at the receive port. That error appears only on a later line write. Queue pointer or count errors appear as reordered, duplicated or missing words, but only once back-pressure lets the queue fill. The scoreboard therefore compares every delivered word against an expected queue and requires that queue to empty.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_LINE = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  localparam int MS_W     = 4;
  localparam int LBE_POS  = 7;
  localparam int SBRK_POS = 0;
  localparam int DTR_POS  = 10;
  localparam int RTS_POS  = 11;
  localparam int OUT1_POS = 12;
  localparam int OUT2_POS = 13;

  // flag index: 0 ring, 1 clear-to-send, 2 carrier detect, 3 data-set-ready
  function automatic int ms_src_pos(input int idx);
    case (idx)
      0:       return OUT2_POS;
      1:       return RTS_POS;
      2:       return OUT1_POS;
      default: return DTR_POS;
    endcase
  endfunction

endpackage

// File: rtl/uart_lb_modem.sv
module uart_lb_modem
  import uart_lb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic [MS_W-1:0] mirror,
  output logic [MS_W-1:0] flags,
  output logic [MS_W-1:0] irq
);

  logic [MS_W-1:0] irq_next;

  // clear every modem-status bit, then raise those whose flag is high
  always_comb begin
    irq_next = irq & ~{MS_W{1'b1}};
    for (int i = 0; i < MS_W; i++) begin
      if (mirror[i]) irq_next[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      irq   <= '0;
    end else if (upd) begin
      flags <= mirror;
      irq   <= irq_next;
    end
  end

endmodule

// File: rtl/uart_lb_regs.sv
module uart_lb_regs
  import uart_lb_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int DATA_W = 8,
  parameter int WORD_W = DATA_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  ctrl_q,
  output logic              lb_on,
  output logic [MS_W-1:0]   flags,
  output logic [MS_W-1:0]   irq,
  output logic              lb_push,
  output logic [WORD_W-1:0] lb_word
);

  localparam int BRK_POS = WORD_W - 1;

  reg_sel_e        sel_e;
  logic            brk_q;
  logic            ctrl_wr;
  logic [MS_W-1:0] mirror;

  assign sel_e   = reg_sel_e'(sel);
  assign ctrl_wr = wr && (sel_e == SEL_CTRL);
  assign lb_on   = ctrl_q[LBE_POS];

  for (genvar g = 0; g < MS_W; g++) begin : g_mirror
    assign mirror[g] = wdata[ms_src_pos(g)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      brk_q  <= 1'b0;
    end else if (wr) begin
      if (sel_e == SEL_CTRL) ctrl_q <= wdata;
      if (sel_e == SEL_LINE) brk_q  <= wdata[SBRK_POS];
    end
  end

  uart_lb_modem u_modem (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (ctrl_wr && wdata[LBE_POS]),
    .mirror (mirror),
    .flags  (flags),
    .irq    (irq)
  );

  always_comb begin
    lb_push = 1'b0;
    lb_word = '0;
    if (wr && lb_on) begin
      if (sel_e == SEL_DATA) begin
        lb_push = 1'b1;
        lb_word = {{(WORD_W-DATA_W){1'b0}}, wdata[DATA_W-1:0]};
      end else if (sel_e == SEL_LINE && wdata[SBRK_POS] && !brk_q) begin
        lb_push = 1'b1;
        lb_word[BRK_POS] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_lb_fifo.sv
module uart_lb_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full      = (cnt == CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign do_push   = push && !full;
  assign do_pop    = out_valid && out_ready;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/uart_loopback_path.sv
module uart_loopback_path
  import uart_lb_pkg::*;
#(
  parameter int REG_W      = 16,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int WORD_W    = DATA_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              ext_rx_valid,
  output logic              ext_rx_ready,
  input  logic [DATA_W-1:0] ext_rx_data,
  output logic              rxq_valid,
  input  logic              rxq_ready,
  output logic [WORD_W-1:0] rxq_data,
  output logic [REG_W-1:0]  ctrl_reg,
  output logic [MS_W-1:0]   modem_flags,
  output logic [MS_W-1:0]   modem_irq
);

  logic              lb_on, lb_push, q_full, ext_take, q_push;
  logic [WORD_W-1:0] lb_word, q_word;

  uart_lb_regs #(
    .REG_W  (REG_W),
    .DATA_W (DATA_W),
    .WORD_W (WORD_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .ctrl_q  (ctrl_reg),
    .lb_on   (lb_on),
    .flags   (modem_flags),
    .irq     (modem_irq),
    .lb_push (lb_push),
    .lb_word (lb_word)
  );

  // loopback swallows external characters; otherwise they wait for space
  assign ext_rx_ready = lb_on || !q_full;
  assign ext_take     = ext_rx_valid && !lb_on && !q_full;
  assign q_push       = lb_push || ext_take;
  assign q_word       = lb_push ? lb_word
                                : {{(WORD_W-DATA_W){1'b0}}, ext_rx_data};

  uart_lb_fifo #(
    .W     (WORD_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data (q_word),
    .full      (q_full),
    .out_valid (rxq_valid),
    .out_ready (rxq_ready),
    .out_data  (rxq_data)
  );

endmodule

// File: rtl/uart_loopback_path_chk.sv
module uart_loopback_path_chk
  import uart_lb_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int WORD_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              ext_rx_ready,
  input logic              rxq_valid,
  input logic              rxq_ready,
  input logic [WORD_W-1:0] rxq_data,
  input logic [REG_W-1:0]  ctrl_reg,
  input logic [MS_W-1:0]   modem_flags,
  input logic [MS_W-1:0]   modem_irq
);

  logic ctl_w;
  assign ctl_w = reg_wr && (reg_sel == 2'd3);

  // R2
  cross_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_w && reg_wdata[LBE_POS] |=> modem_flags ==
      {$past(reg_wdata[DTR_POS]), $past(reg_wdata[OUT1_POS]),
       $past(reg_wdata[RTS_POS]), $past(reg_wdata[OUT2_POS])});

  // R3
  irq_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_w && reg_wdata[LBE_POS] |=> modem_irq == modem_flags);

  // R4
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_w |=> ctrl_reg == $past(reg_wdata));

  // R4
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_w && !reg_wdata[LBE_POS] |=> $stable(modem_flags) && $stable(modem_irq));

  // R5
  other_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_w |=> $stable(modem_flags) && $stable(modem_irq));

  // R8
  ext_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_reg[LBE_POS] |-> ext_rx_ready);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_valid && !rxq_ready |=> rxq_valid && $stable(rxq_data));

endmodule

bind uart_loopback_path uart_loopback_path_chk #(
  .REG_W  (REG_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_sel      (reg_sel),
  .reg_wdata    (reg_wdata),
  .ext_rx_ready (ext_rx_ready),
  .rxq_valid    (rxq_valid),
  .rxq_ready    (rxq_ready),
  .rxq_data     (rxq_data),
  .ctrl_reg     (ctrl_reg),
  .modem_flags  (modem_flags),
  .modem_irq    (modem_irq)
);

// File: tb/uart_loopback_path_tb.sv
module uart_loopback_path_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic        ext_rx_valid = 1'b0;
  logic        ext_rx_ready;
  logic [7:0]  ext_rx_data = '0;
  logic        rxq_valid;
  logic        rxq_ready = 1'b1;
  logic [10:0] rxq_data;
  logic [15:0] ctrl_reg;
  logic [3:0]  modem_flags, modem_irq;

  always #5 clk = ~clk;

  uart_loopback_path u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ext_rx_valid(ext_rx_valid),
    .ext_rx_ready(ext_rx_ready), .ext_rx_data(ext_rx_data),
    .rxq_valid(rxq_valid), .rxq_ready(rxq_ready), .rxq_data(rxq_data),
    .ctrl_reg(ctrl_reg), .modem_flags(modem_flags), .modem_irq(modem_irq)
  );

  int          checks = 0;
  int          errors = 0;
  logic [10:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_word(input logic [10:0] w, input string req);
    exp_q.push_back(w);
    tag_q.push_back(req);
  endtask

  // scoreboard monitor: compares each accepted word against the expected queue
  always @(negedge clk) begin
    if (rst_n && rxq_valid && rxq_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected word", rxq_data, 0);
      end else begin
        automatic logic [10:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rxq_data == e, t, "word", rxq_data, e);
      end
    end
  end

  task automatic wreg(input logic [1:0] sel, input logic [15:0] d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic ext_send(input logic [7:0] d);
    @(posedge clk); #2;
    ext_rx_valid = 1'b1; ext_rx_data = d;
    @(posedge clk); #2;
    ext_rx_valid = 1'b0;
  endtask

  task automatic drained(input string req);
    repeat (8) @(posedge clk);
    #2;
    check(exp_q.size() == 0, req, "pending expected words", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check(ctrl_reg == 16'h0, "R1", "ctrl_reg", ctrl_reg, 0);
    check(modem_flags == 4'h0, "R1", "modem_flags", modem_flags, 0);
    check(modem_irq == 4'h0, "R1", "modem_irq", modem_irq, 0);
    check(!rxq_valid, "R1", "rxq_valid", rxq_valid, 0);
    rst_n = 1'b1;

    // R9 external path with loopback off
    expect_word(11'h05A, "R9");
    ext_send(8'h5A);
    expect_word(11'h0C3, "R9");
    ext_send(8'hC3);
    drained("R9");

    // R4 control stored, flags untouched while loopback off
    wreg(2'd3, 16'h3C00);
    check(ctrl_reg == 16'h3C00, "R4", "ctrl_reg", ctrl_reg, 16'h3C00);
    check(modem_flags == 4'h0, "R4", "flags off", modem_flags, 0);
    check(modem_irq == 4'h0, "R4", "irq off", modem_irq, 0);

    // R2 enabling write applies crossed map: DTR+Out2 -> DSR(3)+RI(0)
    wreg(2'd3, 16'h2480);
    check(modem_flags == 4'b1001, "R2", "flags dtr/out2", modem_flags, 4'b1001);
    check(modem_irq == 4'b1001, "R3", "irq dtr/out2", modem_irq, 4'b1001);

    // R3 RTS+Out1 -> CTS(1)+DCD(2), old bits cleared
    wreg(2'd3, 16'h1880);
    check(modem_flags == 4'b0110, "R2", "flags rts/out1", modem_flags, 4'b0110);
    check(modem_irq == 4'b0110, "R3", "irq cleared/reset", modem_irq, 4'b0110);

    // R5 flag register write ignored
    wreg(2'd1, 16'hFFFF);
    check(modem_flags == 4'b0110, "R5", "flags after flag write", modem_flags, 4'b0110);
    check(modem_irq == 4'b0110, "R5", "irq after flag write", modem_irq, 4'b0110);
    check(ctrl_reg == 16'h1880, "R5", "ctrl after flag write", ctrl_reg, 16'h1880);

    // R6 loopback data writes
    expect_word(11'h0A5, "R6");
    wreg(2'd0, 16'h07A5);
    expect_word(11'h033, "R6");
    wreg(2'd0, 16'h0033);
    drained("R6");

    // R8 external characters discarded in loopback
    @(posedge clk); #2;
    ext_rx_valid = 1'b1; ext_rx_data = 8'h77;
    @(negedge clk);
    check(ext_rx_ready, "R8", "ext_rx_ready", ext_rx_ready, 1);
    repeat (2) @(posedge clk);
    #2;
    ext_rx_valid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(!rxq_valid, "R8", "no word from discarded input", rxq_valid, 0);

    // R7 break edge only
    expect_word(11'h400, "R7");
    wreg(2'd2, 16'h0001);
    wreg(2'd2, 16'h0001);
    wreg(2'd2, 16'h0000);
    expect_word(11'h400, "R7");
    wreg(2'd2, 16'h0001);
    drained("R7");
    wreg(2'd2, 16'h0000);

    // R10 back-pressure holds the head word
    rxq_ready = 1'b0;
    expect_word(11'h011, "R10");
    wreg(2'd0, 16'h0011);
    expect_word(11'h022, "R10");
    wreg(2'd0, 16'h0022);
    expect_word(11'h033, "R10");
    wreg(2'd0, 16'h0033);
    repeat (3) @(posedge clk);
    #2;
    check(rxq_valid && rxq_data == 11'h011, "R10", "held head", rxq_data, 11'h011);
    rxq_ready = 1'b1;
    drained("R10");

    // R11 overflow drops late pushes
    rxq_ready = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (i < 4) expect_word(11'(8'h40 + i), "R11");
      wreg(2'd0, 16'(8'h40 + i));
    end
    rxq_ready = 1'b1;
    drained("R11");
    check(!rxq_valid, "R11", "empty after drain", rxq_valid, 0);

    // R4 disabling write keeps flags; R6 data write now pushes nothing
    wreg(2'd3, 16'h0000);
    check(modem_flags == 4'b0110, "R4", "flags hold on disable", modem_flags, 4'b0110);
    wreg(2'd0, 16'h0055);
    repeat (3) @(posedge clk);
    #2;
    check(!rxq_valid, "R6", "no push with loopback off", rxq_valid, 0);

    // R9 external path stalls when queue full
    rxq_ready = 1'b0;
    for (int i = 0; i < 4; i++) begin
      expect_word(11'(8'h90 + i), "R9");
      ext_send(8'(8'h90 + i));
    end
    @(posedge clk); #2;
    ext_rx_valid = 1'b1; ext_rx_data = 8'hEE;
    @(negedge clk);
    check(!ext_rx_ready, "R9", "ready low when full", ext_rx_ready, 0);
    @(posedge clk); #2;
    ext_rx_valid = 1'b0;
    rxq_ready = 1'b1;
    drained("R9");

    finish_run();
  end

endmodule